// File: doc/BRIEF.md
# Compressed radio packet deframer

This block sits on a 64-bit AXI4-Stream carrying compressed radio packets. Every packet opens with a single 64-bit header word that holds the packet kind, a flag saying whether a 64-bit timestamp word follows, an end-of-burst/error flag, a 12-bit sequence number, the total packet size in bytes and a 32-bit stream ID. The block decodes that header while the first beat is being accepted and presents the fields on a sideband. It captures the timestamp word when one is present. Only the payload words go to the output stream.

The output stream carries correct byte-keep and last-beat marks. The payload byte count is taken from the header's length field, which covers the whole packet including the header and timestamp words. The block also follows the sequence numbers from packet to packet, flags packet kinds that no valid header uses, and reports a packet whose beat count does not match its length field. The datapath is a registered-control pass-through. Output backpressure reaches the input directly, and no beat is stored inside the block.

Top module: `cpkt_deframer`

## Requirements
- R1: On the cycle the first beat of a packet is accepted, `hdr_valid` is 1. In that cycle `hdr_kind` shows input bits [63:62], `hdr_has_ts` shows bit 61, `hdr_eob` shows bit 60, `hdr_seq` shows bits [59:48], `hdr_len` shows bits [47:32] and `hdr_sid` shows bits [31:0]. In every other cycle `hdr_valid` is 0.
- R2: `hdr_class` is decoded from header bits {63,62,60}: 000 gives 0 (data), 001 gives 1 (data, end of burst), 010 gives 2 (flow control), 100 gives 3 (command), 110 gives 4 (command response) and 111 gives 5 (command response, error).
- R3: The combinations 011 and 101 give `hdr_class` = 7. `err_type` pulses for one cycle together with `hdr_valid`, and the payload of that packet is still forwarded.
- R4: When bit 61 is 1 and the packet has a second beat, that beat is accepted with `ts_valid` = 1 and `ts_value` equal to the beat. It is not forwarded.
- R5: Only beats after the header (and after the timestamp, when present) appear on the output. They appear unchanged, once each and in order.
- R6: The expected payload byte count is `hdr_len` minus 8, minus 8 more when bit 61 is 1, and 0 if that would be negative. On the payload beat numbered ceil(count/8), `m_tkeep` has its low (count mod 8) bits set, or all 8 bits when the remainder is 0. Every other payload beat has `m_tkeep` = 8'hFF.
- R7: `m_tlast` on an output beat equals the input `s_tlast` of that beat, so the output packet ends where the input packet ends.
- R8: The expected sequence number is 0 after reset. After each header it becomes the received number plus one, wrapping from 4095 to 0. `err_seq` pulses together with `hdr_valid` when the received number differs from the expected one.
- R9: `err_len` pulses on the beat that carries the input `s_tlast` when the packet's payload beat count differs from ceil(count/8). A packet that ends on its header while bit 61 is 1 is a length error. `err_len` is 0 on all other beats.
- R10: Header and timestamp beats are accepted whatever `m_tready` is. During payload, `s_tready` equals `m_tready`.
- R11: After reset, with no input, `s_tready` is 1, `m_tvalid` is 0 and all pulse outputs are 0. The next accepted beat is treated as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 64 | Input beat data |
| s_tlast | input | 1 | Input last beat of packet |
| m_tvalid | output | 1 | Output payload beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 64 | Output payload data |
| m_tkeep | output | 8 | Output byte enables |
| m_tlast | output | 1 | Output last beat |
| hdr_valid | output | 1 | Header fields valid (header beat accepted) |
| hdr_class | output | 3 | Decoded packet class |
| hdr_kind | output | 2 | Raw kind bits [63:62] |
| hdr_has_ts | output | 1 | Timestamp word follows |
| hdr_eob | output | 1 | End-of-burst / error flag |
| hdr_seq | output | 12 | Sequence number |
| hdr_len | output | 16 | Total packet length in bytes |
| hdr_sid | output | 32 | Stream ID |
| ts_valid | output | 1 | Timestamp beat accepted |
| ts_value | output | 64 | Captured timestamp |
| err_seq | output | 1 | Sequence discontinuity pulse |
| err_type | output | 1 | Malformed packet-kind pulse |
| err_len | output | 1 | Length mismatch pulse |

## Verification
The hardest case to reach is a length mismatch at a packet boundary while the output is stalled. In that case the remaining-beat count is already zero, or is still above one, at the moment the input last beat finally gets through. The stimulus generates packets whose beat count differs from the length field by one in either direction. It also sends header-only packets with the timestamp flag set and lengths shorter than the header. Meanwhile a ready generator switches between always ready, random and mostly stalled, so these boundaries are crossed with `m_tready` low as well as high.

// File: rtl/cpkt_pkg.sv
`timescale 1ns/1ps
package cpkt_pkg;
    localparam int DW     = 64;
    localparam int KW     = DW / 8;
    localparam int SEQ_W  = 12;
    localparam int LEN_W  = 16;
    localparam int SID_W  = 32;
    localparam int BEAT_W = LEN_W - 3;
    localparam int HDR_BYTES = KW;

    typedef struct packed {
        logic [1:0]       kind;
        logic             has_ts;
        logic             eob;
        logic [SEQ_W-1:0] seq;
        logic [LEN_W-1:0] len;
        logic [SID_W-1:0] sid;
    } hdr_t;

    typedef enum logic [2:0] {
        CLS_DATA     = 3'd0,
        CLS_DATA_EOB = 3'd1,
        CLS_FLOW     = 3'd2,
        CLS_CMD      = 3'd3,
        CLS_RESP     = 3'd4,
        CLS_RESP_ERR = 3'd5,
        CLS_BAD      = 3'd7
    } pkt_class_e;

    typedef enum logic [1:0] {
        ST_HDR = 2'd0,
        ST_TS  = 2'd1,
        ST_PAY = 2'd2
    } beat_st_e;

    function automatic pkt_class_e classify(input logic [1:0] kind, input logic eob);
        case ({kind, eob})
            3'b000:  return CLS_DATA;
            3'b001:  return CLS_DATA_EOB;
            3'b010:  return CLS_FLOW;
            3'b100:  return CLS_CMD;
            3'b110:  return CLS_RESP;
            3'b111:  return CLS_RESP_ERR;
            default: return CLS_BAD;
        endcase
    endfunction

    function automatic logic [KW-1:0] tail_keep(input logic [2:0] rem_bytes);
        logic [KW-1:0] m;
        m = '0;
        for (int i = 0; i < KW; i++) begin
            if (i < int'(rem_bytes)) m[i] = 1'b1;
        end
        if (rem_bytes == 3'd0) m = '1;
        return m;
    endfunction
endpackage

// File: rtl/cpkt_hdr_decode.sv
`timescale 1ns/1ps
module cpkt_hdr_decode
    import cpkt_pkg::*;
(
    input  logic [DW-1:0]     word,
    output hdr_t              hdr,
    output pkt_class_e        cls,
    output logic [BEAT_W-1:0] pay_beats,
    output logic [KW-1:0]     pay_tail
);
    logic [LEN_W-1:0] ovh;
    logic [LEN_W-1:0] pay_bytes;

    assign hdr = hdr_t'(word);
    assign cls = classify(hdr.kind, hdr.eob);

    // header word, plus the timestamp word when flagged
    assign ovh       = hdr.has_ts ? LEN_W'(2 * HDR_BYTES) : LEN_W'(HDR_BYTES);
    assign pay_bytes = (hdr.len > ovh) ? (hdr.len - ovh) : '0;
    assign pay_beats = pay_bytes[LEN_W-1:3] + BEAT_W'(|pay_bytes[2:0]);
    assign pay_tail  = tail_keep(pay_bytes[2:0]);
endmodule

// File: rtl/cpkt_seq_track.sv
`timescale 1ns/1ps
module cpkt_seq_track
    import cpkt_pkg::*;
#(
    parameter int SW = SEQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hdr_fire,
    input  logic [SW-1:0] seq_in,
    output logic          err_seq
);
    logic [SW-1:0] exp_q;

    assign err_seq = hdr_fire && (seq_in != exp_q);

    always_ff @(posedge clk) begin
        if (rst)           exp_q <= '0;
        else if (hdr_fire) exp_q <= seq_in + SW'(1);
    end

    AST_SEQ_RESYNC: assert property (@(posedge clk) disable iff (rst)
        hdr_fire |=> exp_q == SW'($past(seq_in) + SW'(1))); // R8
    AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hdr_fire |=> $stable(exp_q)); // R8
endmodule

// File: rtl/cpkt_beat_ctrl.sv
`timescale 1ns/1ps
module cpkt_beat_ctrl
    import cpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    input  logic              m_tready,
    input  logic              pkt_has_ts,
    input  logic [BEAT_W-1:0] pkt_beats,
    input  logic [KW-1:0]     pkt_tail,
    output logic              s_tready,
    output logic              m_tvalid,
    output logic [KW-1:0]     m_tkeep,
    output logic              hdr_fire,
    output logic              ts_fire,
    output logic              err_len
);
    beat_st_e          st;
    logic [BEAT_W-1:0] rem;
    logic [KW-1:0]     tail_q;
    logic              in_pay;
    logic              pay_fire;
    logic              fire;

    assign in_pay   = (st == ST_PAY);
    assign s_tready = in_pay ? m_tready : 1'b1;
    assign fire     = s_tvalid && s_tready;
    assign hdr_fire = fire && (st == ST_HDR);
    assign ts_fire  = fire && (st == ST_TS);
    assign pay_fire = fire && in_pay;
    assign m_tvalid = s_tvalid && in_pay;
    assign m_tkeep  = (rem == BEAT_W'(1)) ? tail_q : '1;

    assign err_len = s_tlast && (
        (hdr_fire && (pkt_has_ts || (pkt_beats != '0))) ||
        (ts_fire  && (rem != '0)) ||
        (pay_fire && (rem != BEAT_W'(1))));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HDR;
            rem    <= '0;
            tail_q <= '1;
        end else if (hdr_fire) begin
            rem    <= pkt_beats;
            tail_q <= pkt_tail;
            if (s_tlast)         st <= ST_HDR;
            else if (pkt_has_ts) st <= ST_TS;
            else                 st <= ST_PAY;
        end else if (ts_fire) begin
            st <= s_tlast ? ST_HDR : ST_PAY;
        end else if (pay_fire) begin
            if (rem != '0) rem <= rem - BEAT_W'(1);
            if (s_tlast)   st  <= ST_HDR;
        end
    end

    AST_LAST_TO_HDR: assert property (@(posedge clk) disable iff (rst)
        (fire && s_tlast) |=> st == ST_HDR); // R7
    AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
        (pay_fire && !s_tlast && rem != '0) |=> rem == $past(rem) - BEAT_W'(1)); // R9
    AST_TS_FOLLOWS_HDR: assert property (@(posedge clk) disable iff (rst)
        (hdr_fire && pkt_has_ts && !s_tlast) |=> st == ST_TS); // R4
endmodule

// File: rtl/cpkt_deframer.sv
`timescale 1ns/1ps
module cpkt_deframer
    import cpkt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic [DW-1:0]    s_tdata,
    input  logic             s_tlast,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic [DW-1:0]    m_tdata,
    output logic [KW-1:0]    m_tkeep,
    output logic             m_tlast,
    output logic             hdr_valid,
    output logic [2:0]       hdr_class,
    output logic [1:0]       hdr_kind,
    output logic             hdr_has_ts,
    output logic             hdr_eob,
    output logic [SEQ_W-1:0] hdr_seq,
    output logic [LEN_W-1:0] hdr_len,
    output logic [SID_W-1:0] hdr_sid,
    output logic             ts_valid,
    output logic [DW-1:0]    ts_value,
    output logic             err_seq,
    output logic             err_type,
    output logic             err_len
);
    hdr_t              hdr;
    pkt_class_e        cls;
    logic [BEAT_W-1:0] pay_beats;
    logic [KW-1:0]     pay_tail;
    logic              hdr_fire;
    logic              ts_fire;

    cpkt_hdr_decode u_dec (
        .word      (s_tdata),
        .hdr       (hdr),
        .cls       (cls),
        .pay_beats (pay_beats),
        .pay_tail  (pay_tail)
    );

    cpkt_beat_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .m_tready   (m_tready),
        .pkt_has_ts (hdr.has_ts),
        .pkt_beats  (pay_beats),
        .pkt_tail   (pay_tail),
        .s_tready   (s_tready),
        .m_tvalid   (m_tvalid),
        .m_tkeep    (m_tkeep),
        .hdr_fire   (hdr_fire),
        .ts_fire    (ts_fire),
        .err_len    (err_len)
    );

    cpkt_seq_track #(.SW(SEQ_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .hdr_fire (hdr_fire),
        .seq_in   (hdr.seq),
        .err_seq  (err_seq)
    );

    assign m_tdata    = s_tdata;
    assign m_tlast    = s_tlast;
    assign hdr_valid  = hdr_fire;
    assign hdr_class  = cls;
    assign hdr_kind   = hdr.kind;
    assign hdr_has_ts = hdr.has_ts;
    assign hdr_eob    = hdr.eob;
    assign hdr_seq    = hdr.seq;
    assign hdr_len    = hdr.len;
    assign hdr_sid    = hdr.sid;
    assign ts_valid   = ts_fire;
    assign ts_value   = s_tdata;
    assign err_type   = hdr_fire && (cls == CLS_BAD);

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |-> !s_tready); // R10
    AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (rst)
        m_tvalid |-> (m_tkeep != '0) && ((m_tkeep & (m_tkeep + KW'(1))) == '0)); // R6
    AST_HDR_NOT_OUT: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> !m_tvalid && !ts_valid); // R5
    AST_TYPE_ON_HDR: assert property (@(posedge clk) disable iff (rst)
        err_type |-> hdr_valid); // R3
endmodule

// File: tb/test_cpkt_deframer.sv
`timescale 1ns/1ps
module test_cpkt_deframer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [63:0] s_tdata = '0;
    logic        s_tlast = 1'b0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [63:0] m_tdata;
    logic [7:0]  m_tkeep;
    logic        m_tlast;
    logic        hdr_valid;
    logic [2:0]  hdr_class;
    logic [1:0]  hdr_kind;
    logic        hdr_has_ts;
    logic        hdr_eob;
    logic [11:0] hdr_seq;
    logic [15:0] hdr_len;
    logic [31:0] hdr_sid;
    logic        ts_valid;
    logic [63:0] ts_value;
    logic        err_seq;
    logic        err_type;
    logic        err_len;

    int n_cmp = 0;
    int n_bad = 0;
    int ready_mode = 0;
    logic [11:0] exp_seq = 12'd0;
    logic [63:0] q_data[$];
    logic [7:0]  q_keep[$];
    logic        q_last[$];

    always #2 clk = ~clk;

    cpkt_deframer i_cpkt_deframer (
        .clk(clk), .rst(rst),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
        .m_tlast(m_tlast),
        .hdr_valid(hdr_valid), .hdr_class(hdr_class), .hdr_kind(hdr_kind),
        .hdr_has_ts(hdr_has_ts), .hdr_eob(hdr_eob), .hdr_seq(hdr_seq),
        .hdr_len(hdr_len), .hdr_sid(hdr_sid),
        .ts_valid(ts_valid), .ts_value(ts_value),
        .err_seq(err_seq), .err_type(err_type), .err_len(err_len)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_class(input logic [1:0] kind, input logic eob);
        case ({kind, eob})
            3'b000: return 3'd0;
            3'b001: return 3'd1;
            3'b010: return 3'd2;
            3'b100: return 3'd3;
            3'b110: return 3'd4;
            3'b111: return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [7:0] exp_keep(input int r);
        if (r == 0) return 8'hFF;
        return 8'((1 << r) - 1);
    endfunction

    // ready generator: 0 always ready, 1 random, 2 mostly stalled
    initial begin
        forever begin
            @(posedge clk); #1;
            case (ready_mode)
                0: m_tready = 1'b1;
                1: m_tready = ($urandom % 2) == 0;
                default: m_tready = ($urandom % 4) == 0;
            endcase
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && m_tvalid && m_tready) begin
                if (q_data.size() == 0) begin
                    chk("R5 unexpected output beat", 64'd1, 64'd0);
                end else begin
                    chk("R5 payload data", m_tdata, q_data.pop_front());
                    chk("R6 keep", {56'd0, m_tkeep}, {56'd0, q_keep.pop_front()});
                    chk("R7 last", {63'd0, m_tlast}, {63'd0, q_last.pop_front()});
                end
            end
        end
    end

    task automatic send_pkt(input logic [1:0] kind, input logic eob, input logic ts,
                            input logic [11:0] seq, input int total, input int len,
                            input logic [31:0] sid, input int gap);
        int ovh, bytes, pbeats, has_ts_beat, act_pay, waits;
        logic exp_err_len, exp_err_seq;
        logic [63:0] word;
        logic [63:0] tsw;
        ovh = ts ? 16 : 8;
        bytes = (len > ovh) ? len - ovh : 0;
        pbeats = (bytes + 7) / 8;
        has_ts_beat = (ts && total > 1) ? 1 : 0;
        act_pay = total - 1 - has_ts_beat;
        exp_err_len = (ts && total == 1) || (act_pay != pbeats);
        exp_err_seq = (seq != exp_seq);
        exp_seq = seq + 12'd1;
        tsw = {$urandom, $urandom};
        for (int b = 0; b < total; b++) begin
            logic last;
            last = (b == total - 1);
            if (int'($urandom % 100) < gap) begin
                s_tvalid = 1'b0;
                @(posedge clk); #1;
            end
            if (b == 0) word = {kind, ts, eob, seq, 16'(len), sid};
            else if (b == 1 && has_ts_beat == 1) word = tsw;
            else begin
                int pi;
                pi = b - 1 - has_ts_beat;
                word = {$urandom, $urandom};
                q_data.push_back(word);
                q_keep.push_back((pi == pbeats - 1) ? exp_keep(bytes % 8) : 8'hFF);
                q_last.push_back(last);
            end
            s_tvalid = 1'b1;
            s_tdata = word;
            s_tlast = last;
            waits = 0;
            forever begin
                @(negedge clk);
                if (s_tready) break;
                waits++;
            end
            chk("R9 err_len", {63'd0, err_len}, {63'd0, last ? exp_err_len : 1'b0});
            if (b == 0) begin
                chk("R10 header accepted without wait", 64'(waits), 64'd0);
                chk("R1 hdr_valid", {63'd0, hdr_valid}, 64'd1);
                chk("R1 kind", {62'd0, hdr_kind}, {62'd0, kind});
                chk("R1 has_ts", {63'd0, hdr_has_ts}, {63'd0, ts});
                chk("R1 eob", {63'd0, hdr_eob}, {63'd0, eob});
                chk("R1 seq", {52'd0, hdr_seq}, {52'd0, seq});
                chk("R1 len", {48'd0, hdr_len}, 64'(len & 16'hFFFF));
                chk("R1 sid", {32'd0, hdr_sid}, {32'd0, sid});
                chk("R2 class", {61'd0, hdr_class}, {61'd0, exp_class(kind, eob)});
                chk("R3 err_type", {63'd0, err_type},
                    {63'd0, exp_class(kind, eob) == 3'd7});
                chk("R8 err_seq", {63'd0, err_seq}, {63'd0, exp_err_seq});
                chk("R5 header not forwarded", {63'd0, m_tvalid}, 64'd0);
            end else begin
                chk("R1 hdr_valid low off header", {63'd0, hdr_valid}, 64'd0);
                if (b == 1 && has_ts_beat == 1) begin
                    chk("R4 ts_valid", {63'd0, ts_valid}, 64'd1);
                    chk("R4 ts_value", ts_value, tsw);
                    chk("R4 timestamp not forwarded", {63'd0, m_tvalid}, 64'd0);
                    chk("R10 ts accepted without wait", 64'(waits), 64'd0);
                end else begin
                    chk("R4 ts_valid low on payload", {63'd0, ts_valid}, 64'd0);
                end
            end
            @(posedge clk); #1;
            s_tvalid = 1'b0;
            s_tlast = 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 s_tready after reset", {63'd0, s_tready}, 64'd1);
        chk("R11 m_tvalid after reset", {63'd0, m_tvalid}, 64'd0);
        chk("R11 pulses idle", {60'd0, hdr_valid, err_seq, err_type, err_len}, 64'd0);
        @(posedge clk); #1;

        // R11 first header, R8 expected 0; R6 exact three beats
        send_pkt(2'b00, 1'b0, 1'b0, 12'd0, 4, 32, 32'h1111_0001, 0);
        // R4 timestamp, R6 partial tail of 5 bytes
        send_pkt(2'b00, 1'b1, 1'b1, 12'd1, 4, 29, 32'h1111_0002, 0);
        // R2 classes and R3 malformed combos with payload
        send_pkt(2'b01, 1'b0, 1'b0, 12'd2, 2, 12, 32'hA, 20);
        send_pkt(2'b10, 1'b0, 1'b0, 12'd3, 2, 16, 32'hB, 20);
        send_pkt(2'b11, 1'b0, 1'b0, 12'd4, 3, 17, 32'hC, 20);
        send_pkt(2'b11, 1'b1, 1'b0, 12'd5, 2, 9, 32'hD, 20);
        send_pkt(2'b01, 1'b1, 1'b0, 12'd6, 3, 24, 32'hE, 20); // R3 011
        send_pkt(2'b10, 1'b1, 1'b1, 12'd7, 3, 26, 32'hF, 20); // R3 101
        // R8 wrap and resync
        send_pkt(2'b00, 1'b0, 1'b0, 12'd4095, 2, 16, 32'h10, 0);
        send_pkt(2'b00, 1'b0, 1'b0, 12'd0, 2, 16, 32'h11, 0);
        send_pkt(2'b00, 1'b0, 1'b0, 12'd5, 2, 16, 32'h12, 0);
        send_pkt(2'b00, 1'b0, 1'b0, 12'd6, 1, 8, 32'h13, 0);
        // R9 short, long, header-only with ts flag, undersized length, ts-only
        ready_mode = 2;
        send_pkt(2'b00, 1'b0, 1'b0, 12'd7, 3, 40, 32'h20, 0);
        send_pkt(2'b00, 1'b0, 1'b0, 12'd8, 5, 20, 32'h21, 0);
        send_pkt(2'b00, 1'b0, 1'b1, 12'd9, 1, 16, 32'h22, 0);
        send_pkt(2'b00, 1'b0, 1'b0, 12'd10, 1, 3, 32'h23, 0);
        send_pkt(2'b00, 1'b0, 1'b1, 12'd11, 2, 16, 32'h24, 0);
        send_pkt(2'b00, 1'b0, 1'b1, 12'd12, 3, 16, 32'h25, 0);

        // random mix under R10 backpressure
        for (int n = 0; n < 120; n++) begin
            logic ts;
            int pbytes, total, len;
            logic [11:0] seq;
            ready_mode = int'($urandom % 3);
            ts = $urandom % 2;
            pbytes = int'($urandom % 41);
            len = 8 + (ts ? 8 : 0) + pbytes;
            total = 1 + (ts ? 1 : 0) + (pbytes + 7) / 8;
            if ($urandom % 5 == 0) begin
                if ($urandom % 2 == 0) total = total + 1;
                else if (total > 1) total = total - 1;
            end
            seq = ($urandom % 6 == 0) ? 12'($urandom) : exp_seq;
            send_pkt(2'($urandom), 1'($urandom), ts, seq, total, len, $urandom, 30);
        end

        ready_mode = 0;
        repeat (10) @(posedge clk);
        #1;
        chk("R5 all payload delivered", 64'(q_data.size()), 64'd0);
        finish_run();
    end
endmodule